// File: doc/BRIEF.md
# Line Test Error Injector

This block sits in the transmit path just after an alternate-mark-inversion line encoder. Each clock it takes one encoded symbol on two rails, positive and negative, together with the unencoded data bit that produced it. It passes both to its outputs one clock later. On command it corrupts the stream so that a far-end receiver's error counters can be tested.

There are two independent one-shot commands. A rising edge on the violation request arms the block. It then waits for a data bit of 1 whose two preceding data bits were also 1. That bit's mark is sent with the same polarity as the previous mark, which gives one bipolar violation. Every later mark keeps alternating from the polarity actually sent. A rising edge on the bit-error request inverts the next data bit on the unencoded output. Each command performs one insertion per rising edge and raises a one-cycle done flag together with the corrupted output.

Top module: `line_err_inject`

## Requirements
- R1: While `rst_n` is low and on the first output after it, `pos_out`, `neg_out`, `data_out`, `bpv_done` and `logic_done` are all 0.
- R2: With no insertion pending, `data_out` equals `data_in` from one clock earlier, and the rails are passed through. No violation is produced even when many consecutive ones arrive.
- R3: A 0-to-1 change of `bpv_req`, sampled on a clock edge, arms one violation. Bits presented at later edges are eligible; the bit presented at the arming edge is not.
- R4: While armed, the violation goes onto the first bit with `data_in`=1 and a mark on the rails whose two preceding data bits were 1. Ones before the arming edge count toward the run. That mark is sent on the same rail as the previous mark sent.
- R5: Only one violation is sent per arming. Holding `bpv_req` high sends no more. Another one needs `bpv_req` to go low and then high again.
- R6: A rising edge of `bpv_req` while a violation is still pending is ignored, and no second violation is queued.
- R7: After a violation, marks keep alternating from the polarity actually sent. Every later mark takes the rail opposite to the previous mark sent.
- R8: A 0-to-1 change of `logic_req` inverts exactly one data bit on `data_out`: the bit presented at the next edge after the arming edge. The rails and the violation logic are not affected.
- R9: Another bit error needs `logic_req` to go low and then high again. The request may already be low when the armed bit arrives.
- R10: `bpv_done` and `logic_done` each go high for exactly one cycle, in the same cycle as the output they changed.
- R11: Outputs trail inputs by one clock. A mark on the input is a mark on the output. `pos_out` and `neg_out` are never both high. A high `pos_in` means a positive mark, a high `neg_in` means a negative mark, and both low means a space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, one symbol per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| pos_in | input | 1 | Encoded positive-mark rail |
| neg_in | input | 1 | Encoded negative-mark rail |
| data_in | input | 1 | Unencoded data bit for this symbol |
| bpv_req | input | 1 | Violation request, acts on its rising edge |
| logic_req | input | 1 | Bit-error request, acts on its rising edge |
| pos_out | output | 1 | Positive-mark rail after insertion |
| neg_out | output | 1 | Negative-mark rail after insertion |
| data_out | output | 1 | Data bit after insertion |
| bpv_done | output | 1 | One-cycle flag: violation sent this cycle |
| logic_done | output | 1 | One-cycle flag: bit error sent this cycle |

## Verification
The bench aims at the timing of the run of ones. A pair of ones broken by a zero must not trigger a violation. A run that began before arming must trigger one on its next one. A design that resets its run count at arming, or that counts the arming bit, puts the violation one mark late or early. Edges that arrive while a violation is pending, and a request held high after an insertion, are used to catch a design that queues or repeats insertions. Every mark after a violation is compared with the rail the model expects. This catches a design that returns to the encoder's own polarity and so produces a second, unrequested violation.

// File: rtl/lei_pkg.sv
package lei_pkg;

  // Polarity bit convention: 1 = negative mark, 0 = positive mark.

  // Polarity to transmit for the current mark.
  function automatic logic f_sent_neg(input logic in_neg, input logic swap,
                                      input logic inject, input logic last_neg);
    return inject ? last_neg : (in_neg ^ swap);
  endfunction

  // Rail swap state after this symbol: a violation re-bases the swap so that
  // later encoder marks alternate from the polarity actually sent.
  function automatic logic f_swap_next(input logic in_neg, input logic swap,
                                       input logic inject, input logic last_neg);
    return inject ? (in_neg ^ last_neg) : swap;
  endfunction

  // Map a mark and its polarity onto {pos, neg} rails.
  function automatic logic [1:0] f_rails(input logic mark, input logic neg);
    return {mark & ~neg, mark & neg};
  endfunction

endpackage

// File: rtl/lei_oneshot.sv
module lei_oneshot (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic fire,
  output logic pending
);
  logic req_q;
  logic rise;

  assign rise = req & ~req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      pending <= 1'b0;
    end else begin
      req_q   <= req;
      // An edge while pending is dropped; firing clears the request.
      pending <= pending ? ~fire : rise;
    end
  end
endmodule

// File: rtl/lei_run_tracker.sv
module lei_run_tracker #(
  parameter int RUN_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic data_in,
  output logic run_met
);
  localparam int CW = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
  localparam logic [CW-1:0] PRIOR = CW'(RUN_LEN - 1);

  logic [CW-1:0] ones_cnt;

  // Current bit is a one and enough ones came just before it.
  assign run_met = data_in & (ones_cnt == PRIOR);

  always_ff @(posedge clk) begin
    if (!rst_n)            ones_cnt <= '0;
    else if (!data_in)     ones_cnt <= '0;
    else if (ones_cnt != PRIOR) ones_cnt <= ones_cnt + 1'b1;
  end
endmodule

// File: rtl/lei_polarity.sv
module lei_polarity
  import lei_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mark,
  input  logic in_neg,
  input  logic inject,
  output logic sent_neg
);
  logic swap;
  logic last_neg;

  assign sent_neg = f_sent_neg(in_neg, swap, inject, last_neg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      swap     <= 1'b0;
      last_neg <= 1'b1;
    end else begin
      swap <= f_swap_next(in_neg, swap, inject, last_neg);
      if (mark) last_neg <= sent_neg;
    end
  end
endmodule

// File: rtl/line_err_inject.sv
module line_err_inject
  import lei_pkg::*;
#(
  parameter int RUN_LEN = 3,
  parameter int N_REQ   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pos_in,
  input  logic neg_in,
  input  logic data_in,
  input  logic bpv_req,
  input  logic logic_req,
  output logic pos_out,
  output logic neg_out,
  output logic data_out,
  output logic bpv_done,
  output logic logic_done
);
  localparam int K_BPV = 0;
  localparam int K_LE  = 1;

  logic [N_REQ-1:0] req_v;
  logic [N_REQ-1:0] fire_v;
  logic [N_REQ-1:0] pend_v;

  logic mark;
  logic in_neg;
  logic run_met;
  logic inject;   // violation performed on this symbol
  logic le_fire;  // bit error performed on this symbol
  logic sent_neg;
  logic [1:0] rails;

  assign mark   = pos_in | neg_in;
  assign in_neg = neg_in & ~pos_in;

  assign req_v[K_BPV] = bpv_req;
  assign req_v[K_LE]  = logic_req;

  assign inject  = pend_v[K_BPV] & run_met & mark;
  assign le_fire = pend_v[K_LE];

  assign fire_v[K_BPV] = inject;
  assign fire_v[K_LE]  = le_fire;

  genvar gi;
  generate
    for (gi = 0; gi < N_REQ; gi++) begin : g_arm
      lei_oneshot u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_v[gi]),
        .fire    (fire_v[gi]),
        .pending (pend_v[gi])
      );
    end
  endgenerate

  lei_run_tracker #(.RUN_LEN(RUN_LEN)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .data_in (data_in),
    .run_met (run_met)
  );

  lei_polarity u_pol (
    .clk      (clk),
    .rst_n    (rst_n),
    .mark     (mark),
    .in_neg   (in_neg),
    .inject   (inject),
    .sent_neg (sent_neg)
  );

  assign rails = f_rails(mark, sent_neg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_out    <= 1'b0;
      neg_out    <= 1'b0;
      data_out   <= 1'b0;
      bpv_done   <= 1'b0;
      logic_done <= 1'b0;
    end else begin
      pos_out    <= rails[1];
      neg_out    <= rails[0];
      data_out   <= data_in ^ le_fire;
      bpv_done   <= inject;
      logic_done <= le_fire;
    end
  end
endmodule

// File: rtl/lei_checker.sv
module lei_checker (
  input logic clk,
  input logic rst_n,
  input logic pos_in,
  input logic neg_in,
  input logic data_in,
  input logic pos_out,
  input logic neg_out,
  input logic data_out,
  input logic bpv_done,
  input logic logic_done,
  input logic inject
);
  logic past_ok;
  logic last_out_neg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      past_ok      <= 1'b0;
      last_out_neg <= 1'b1;
    end else begin
      past_ok <= 1'b1;
      if (pos_out | neg_out) last_out_neg <= neg_out;
    end
  end

  a_r11_rails_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pos_out && neg_out));

  a_r11_mark_kept: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((pos_out | neg_out) == $past(pos_in | neg_in)));

  a_r8_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((data_out != $past(data_in)) == logic_done));

  a_r4_same_rail: assert property (@(posedge clk) disable iff (!rst_n)
    bpv_done |-> ((pos_out | neg_out) && (neg_out == last_out_neg)));

  a_r4_on_third_one: assert property (@(posedge clk) disable iff (!rst_n)
    inject |-> (data_in && past_ok && $past(data_in)));

  a_r10_bpv_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bpv_done |=> !bpv_done);

  a_r10_le_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    logic_done |=> !logic_done);
endmodule

bind line_err_inject lei_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pos_in     (pos_in),
  .neg_in     (neg_in),
  .data_in    (data_in),
  .pos_out    (pos_out),
  .neg_out    (neg_out),
  .data_out   (data_out),
  .bpv_done   (bpv_done),
  .logic_done (logic_done),
  .inject     (inject)
);

// File: tb/line_err_inject_tb.sv
module line_err_inject_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic pos_in, neg_in, data_in, bpv_req, logic_req;
  logic pos_out, neg_out, data_out, bpv_done, logic_done;

  int checks = 0;
  int errors = 0;

  // Bench model state: encoder polarity, expected last sent polarity, swap.
  logic enc_neg  = 1'b1;
  logic exp_last = 1'b1;
  logic exp_swap = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_err_inject u_dut (
    .clk(clk), .rst_n(rst_n), .pos_in(pos_in), .neg_in(neg_in),
    .data_in(data_in), .bpv_req(bpv_req), .logic_req(logic_req),
    .pos_out(pos_out), .neg_out(neg_out), .data_out(data_out),
    .bpv_done(bpv_done), .logic_done(logic_done)
  );

  task automatic check(input logic [4:0] act, input logic [4:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {pos,neg,data,bpv_done,le_done} actual %b expected %b",
               tag, act, exp);
    end
  endtask

  // One symbol: d data bit, br/lr request levels, hb/hl expected hits.
  task automatic step(input logic d, input logic br, input logic lr,
                      input logic hb, input logic hl, input string tag);
    logic sneg;
    logic [4:0] exp;
    if (d) enc_neg = ~enc_neg;
    pos_in    = d & ~enc_neg;
    neg_in    = d & enc_neg;
    data_in   = d;
    bpv_req   = br;
    logic_req = lr;
    sneg = 1'b0;
    if (d) begin
      if (hb) begin
        sneg = exp_last;
        exp_swap = enc_neg ^ exp_last;
      end else begin
        sneg = enc_neg ^ exp_swap;
      end
      exp_last = sneg;
    end
    exp = {d & ~sneg, d & sneg, d ^ hl, hb, hl};
    @(posedge clk); #1;
    check({pos_out, neg_out, data_out, bpv_done, logic_done}, exp, tag);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    pos_in = 1'b1; neg_in = 1'b0; data_in = 1'b1; bpv_req = 1'b0; logic_req = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check({pos_out, neg_out, data_out, bpv_done, logic_done}, 5'b0, "R1 in reset");
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1 first output");
  endtask

  task automatic t_pass;
    step(1, 0, 0, 0, 0, "R2 pass");
    step(0, 0, 0, 0, 0, "R2 pass");
    step(1, 0, 0, 0, 0, "R11 pass");
    step(1, 0, 0, 0, 0, "R2 pass");
    step(1, 0, 0, 0, 0, "R2 no violation unarmed");
    step(1, 0, 0, 0, 0, "R2 no violation unarmed");
    step(0, 0, 0, 0, 0, "R11 space");
  endtask

  task automatic t_bpv_basic;
    step(0, 1, 0, 0, 0, "R3 arming bit");
    step(1, 1, 0, 0, 0, "R4 first one");
    step(0, 1, 0, 0, 0, "R4 run broken");
    step(1, 1, 0, 0, 0, "R4 one");
    step(1, 1, 0, 0, 0, "R4 two");
    step(1, 1, 0, 1, 0, "R4 R10 violation on third one");
    step(1, 1, 0, 0, 0, "R7 alternation after violation");
    step(0, 1, 0, 0, 0, "R5 held");
    step(1, 1, 0, 0, 0, "R5 held");
    step(1, 1, 0, 0, 0, "R5 held");
    step(1, 1, 0, 0, 0, "R5 no second violation");
    step(1, 1, 0, 0, 0, "R7 alternation");
  endtask

  task automatic t_bpv_rearm;
    step(0, 0, 0, 0, 0, "R5 clear");
    step(0, 1, 0, 0, 0, "R5 rearm");
    step(1, 1, 0, 0, 0, "R5 one");
    step(1, 1, 0, 0, 0, "R5 two");
    step(1, 1, 0, 1, 0, "R5 second arming violation");
    step(1, 1, 0, 0, 0, "R7 alternation");
    step(0, 0, 0, 0, 0, "R7 space");
  endtask

  task automatic t_bpv_ignore;
    step(0, 1, 0, 0, 0, "R6 arm");
    step(1, 0, 0, 0, 0, "R6 one");
    step(1, 1, 0, 0, 0, "R6 edge while pending");
    step(1, 1, 0, 1, 0, "R6 single violation");
    step(1, 1, 0, 0, 0, "R6 nothing queued");
    step(1, 1, 0, 0, 0, "R6 nothing queued");
    step(1, 1, 0, 0, 0, "R6 nothing queued");
    step(0, 0, 0, 0, 0, "R6 space");
  endtask

  task automatic t_bpv_prerun;
    step(1, 0, 0, 0, 0, "R4 run before arm");
    step(1, 0, 0, 0, 0, "R4 run before arm");
    step(1, 1, 0, 0, 0, "R3 arming bit not eligible");
    step(1, 1, 0, 1, 0, "R4 run counted across arming");
    step(1, 1, 0, 0, 0, "R7 alternation");
    step(0, 0, 0, 0, 0, "R7 space");
  endtask

  task automatic t_logic;
    step(0, 0, 1, 0, 0, "R8 arm");
    step(1, 0, 1, 0, 1, "R8 R10 bit inverted");
    step(0, 0, 1, 0, 0, "R9 held no error");
    step(1, 0, 1, 0, 0, "R9 held no error");
    step(0, 0, 0, 0, 0, "R9 clear");
    step(1, 0, 1, 0, 0, "R9 rearm");
    step(1, 0, 0, 0, 1, "R9 fires with request low");
    step(0, 0, 0, 0, 0, "R8 one error only");
  endtask

  task automatic t_both;
    step(0, 1, 1, 0, 0, "R8 both armed");
    step(1, 1, 1, 0, 1, "R8 error does not disturb run");
    step(1, 1, 1, 0, 0, "R4 run");
    step(1, 1, 1, 1, 0, "R4 violation after bit error");
    step(1, 0, 0, 0, 0, "R7 alternation");
    step(0, 0, 0, 0, 0, "R11 space");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_pass();
    t_bpv_basic();
    t_bpv_rearm();
    t_bpv_ignore();
    t_bpv_prerun();
    t_logic();
    t_both();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule